// File: doc/BRIEF.md
# Four-Channel Periodic Timeout Generator

This block produces four independent, repeating time-outs from the bus clock. A shared prescaler (the micro-timer) divides the clock and emits one tick each time it underflows. Each channel has its own down-counter that steps on those ticks. When a channel's counter expires, the channel sets its time-out flag and drives a one-cycle pulse on its own trigger line for other peripherals. It also raises its interrupt line while the flag is set, provided that channel's interrupt enable is on. The counter then reloads itself, so the time-outs repeat with no software action.

Software configures the block through a small synchronous register port. That port holds the global run bit, the per-channel enables, the per-channel interrupt enables, the prescaler and channel reload values, a write-one-to-clear flag register, and a force-load command. The force-load restarts the prescaler and every channel counter from their reload values. Clearing any enable bit also drops the flags it governs.

Top module: `quad_pit`

## Requirements
- R1: With prescaler reload M and channel reload L, an enabled channel times out every (M+1)*(L+1) clock cycles. The first time-out falls that many cycles after the edge that sets the run bit, and the reload is automatic, so the time-outs repeat periodically.
- R2: A time-out sets the channel's flag and raises its trigger output at the same clock edge. The trigger stays high for exactly one cycle when the period is two cycles or more.
- R3: Interrupt output i is high exactly when flag i and interrupt enable i are both set.
- R4: Writing the flag register (address 3, bit i = channel i) clears every flag whose data bit is one. Data bits that are zero leave their flags unchanged.
- R5: When a flag-clear write and a new time-out of the same channel fall in the same cycle, the flag ends up set.
- R6: Clearing the run bit clears all flags. Clearing a channel-enable bit (address 1) or an interrupt-enable bit (address 2) clears that channel's flag.
- R7: While the run bit is low, nothing counts. No trigger pulses and no flags appear, whatever the other registers hold, and the other registers may be written in any order.
- R8: Writing address 0 with bit 1 set (force-load) restarts the prescaler and all channel counters from their reload values. The next time-out then comes one full period after that write edge.
- R9: A disabled channel keeps its trigger low and holds its counter at its reload value. When the channel is enabled, it counts its L+1 ticks from that point.
- R10: Register map: address 0 bit 0 = run (bit 1 reads zero), address 1 = channel enables, address 2 = interrupt enables, address 3 = flags, address 4 = prescaler reload (8 bits), addresses 8..11 = channel 0..3 reload (16 bits). Other addresses read zero, and everything resets to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| trig_o | output | 4 | Per-channel time-out trigger pulses |
| irq_o | output | 4 | Per-channel interrupt requests |

## Verification
A wrong count in the prescaler or in a channel counter shifts the trigger pulses away from the multiples of (M+1)*(L+1). Such a fault therefore shows on trig_o within one period of the faulty channel, and the bench compares trig_o on every cycle of each sweep. A wrong flag or enable state appears on the flag register and on irq_o within one cycle of the write or time-out that caused it. A counter that keeps running while disabled shows as a trigger at the wrong phase after the channel is re-enabled.

// File: rtl/quad_pit_pkg.sv
package quad_pit_pkg;
  localparam int NCH    = 4;
  localparam int REG_AW = 4;

  localparam logic [REG_AW-1:0] A_CTRL = 4'h0;
  localparam logic [REG_AW-1:0] A_CHEN = 4'h1;
  localparam logic [REG_AW-1:0] A_IEN  = 4'h2;
  localparam logic [REG_AW-1:0] A_FLAG = 4'h3;
  localparam logic [REG_AW-1:0] A_MTLD = 4'h4;
  localparam logic [REG_AW-1:0] A_LD0  = 4'h8;

  // Flags after one cycle: a kill wins over everything, a hit wins over a clear.
  function automatic logic [NCH-1:0] flag_next(input logic [NCH-1:0] cur,
                                               input logic [NCH-1:0] clr,
                                               input logic [NCH-1:0] hit,
                                               input logic [NCH-1:0] kill);
    return ((cur & ~clr) | hit) & ~kill;
  endfunction

  // Bits that go from one to zero on an enable write.
  function automatic logic [NCH-1:0] dropped(input logic [NCH-1:0] old_v,
                                             input logic [NCH-1:0] new_v);
    return old_v & ~new_v;
  endfunction

  // Period of a channel in clock cycles.
  function automatic int unsigned period_cycles(input int unsigned mt,
                                                input int unsigned ld);
    return (mt + 1) * (ld + 1);
  endfunction
endpackage

// File: rtl/pit_regs.sv
module pit_regs
  import quad_pit_pkg::*;
#(
  parameter int MT_W  = 8,
  parameter int CNT_W = 16,
  parameter int DW    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [REG_AW-1:0]     addr,
  input  logic [DW-1:0]         wdata,
  input  logic [NCH-1:0]        timeout,
  output logic                  run,
  output logic [NCH-1:0]        chen,
  output logic [NCH-1:0]        ien,
  output logic [NCH-1:0]        flags,
  output logic [MT_W-1:0]       mt_ld,
  output logic [NCH*CNT_W-1:0]  ld_flat,
  output logic                  force_ld,
  output logic [NCH-1:0]        kill,
  output logic [DW-1:0]         rdata
);
  logic                  run_q;
  logic [NCH-1:0]        chen_q, ien_q, flag_q;
  logic [MT_W-1:0]       mt_q;
  logic [CNT_W-1:0]      ld_q [NCH];

  logic wr_ctrl, wr_chen, wr_ien, wr_flag, wr_mt;
  logic [NCH-1:0] clr_mask;

  assign wr_ctrl = we && (addr == A_CTRL);
  assign wr_chen = we && (addr == A_CHEN);
  assign wr_ien  = we && (addr == A_IEN);
  assign wr_flag = we && (addr == A_FLAG);
  assign wr_mt   = we && (addr == A_MTLD);

  assign force_ld = wr_ctrl && wdata[1];
  assign clr_mask = wr_flag ? wdata[NCH-1:0] : '0;

  always_comb begin
    kill = '0;
    if (wr_ctrl && run_q && !wdata[0]) kill = '1;
    if (wr_chen) kill = kill | dropped(chen_q, wdata[NCH-1:0]);
    if (wr_ien)  kill = kill | dropped(ien_q, wdata[NCH-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      chen_q <= '0;
      ien_q  <= '0;
      flag_q <= '0;
      mt_q   <= '0;
    end else begin
      if (wr_ctrl) run_q  <= wdata[0];
      if (wr_chen) chen_q <= wdata[NCH-1:0];
      if (wr_ien)  ien_q  <= wdata[NCH-1:0];
      if (wr_mt)   mt_q   <= wdata[MT_W-1:0];
      flag_q <= flag_next(flag_q, clr_mask, timeout, kill);
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ld
    logic wr_ld;
    assign wr_ld = we && (addr == (A_LD0 + REG_AW'(i)));
    always_ff @(posedge clk) begin
      if (!rst_n)     ld_q[i] <= '0;
      else if (wr_ld) ld_q[i] <= wdata[CNT_W-1:0];
    end
    assign ld_flat[i*CNT_W +: CNT_W] = ld_q[i];
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata[0]        = run_q;
      A_CHEN:  rdata[NCH-1:0]  = chen_q;
      A_IEN:   rdata[NCH-1:0]  = ien_q;
      A_FLAG:  rdata[NCH-1:0]  = flag_q;
      A_MTLD:  rdata[MT_W-1:0] = mt_q;
      default: begin
        for (int i = 0; i < NCH; i++)
          if (addr == (A_LD0 + REG_AW'(i))) rdata[CNT_W-1:0] = ld_q[i];
      end
    endcase
  end

  assign run   = run_q;
  assign chen  = chen_q;
  assign ien   = ien_q;
  assign flags = flag_q;
  assign mt_ld = mt_q;
endmodule

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int MT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            force_ld,
  input  logic [MT_W-1:0] mt_ld,
  output logic            tick
);
  logic [MT_W-1:0] cnt_q;

  assign tick = run && !force_ld && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run || force_ld) cnt_q <= mt_ld;
    else if (cnt_q == '0)      cnt_q <= mt_ld;
    else                       cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/pit_channel.sv
module pit_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             force_ld,
  input  logic             tick,
  input  logic [CNT_W-1:0] ld,
  input  logic             kill,
  output logic             timeout,
  output logic             trig
);
  logic [CNT_W-1:0] cnt_q;
  logic             trig_q;

  assign timeout = active && !force_ld && tick && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      trig_q <= 1'b0;
    end else begin
      trig_q <= timeout && !kill;
      if (!active || force_ld) cnt_q <= ld;
      else if (tick)           cnt_q <= (cnt_q == '0) ? ld : cnt_q - 1'b1;
    end
  end

  assign trig = trig_q;
endmodule

// File: rtl/quad_pit.sv
module quad_pit
  import quad_pit_pkg::*;
#(
  parameter int MT_W  = 8,
  parameter int CNT_W = 16,
  parameter int DW    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NCH-1:0]    trig_o,
  output logic [NCH-1:0]    irq_o
);
  logic                 run, force_ld, tick;
  logic [NCH-1:0]       chen, ien, flags, kill, timeout;
  logic [MT_W-1:0]      mt_ld;
  logic [NCH*CNT_W-1:0] ld_flat;

  pit_regs #(.MT_W(MT_W), .CNT_W(CNT_W), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .timeout(timeout), .run(run), .chen(chen), .ien(ien), .flags(flags),
    .mt_ld(mt_ld), .ld_flat(ld_flat), .force_ld(force_ld), .kill(kill),
    .rdata(bus_rdata)
  );

  pit_prescaler #(.MT_W(MT_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .force_ld(force_ld),
    .mt_ld(mt_ld), .tick(tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pit_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .active(run && chen[i]), .force_ld(force_ld),
      .tick(tick), .ld(ld_flat[i*CNT_W +: CNT_W]), .kill(kill[i]),
      .timeout(timeout[i]), .trig(trig_o[i])
    );
  end

  assign irq_o = flags & ien;
endmodule

// File: rtl/pit_chk.sv
module pit_chk
  import quad_pit_pkg::*;
#(
  parameter int DW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              we,
  input logic [REG_AW-1:0] addr,
  input logic [DW-1:0]     wdata,
  input logic              tick,
  input logic [NCH-1:0]    timeout,
  input logic [NCH-1:0]    kill,
  input logic [NCH-1:0]    flags,
  input logic [NCH-1:0]    trig
);
  p_quiet_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (trig == '0 && timeout == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_a
    p_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
      timeout[i] |-> tick);
    p_trig_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trig[i]) |-> flags[i]);
    p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == A_FLAG && wdata[i] && !timeout[i]) |=> !flags[i]);
    p_hit_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout[i] && !kill[i]) |=> flags[i]);
    p_kill_r6: assert property (@(posedge clk) disable iff (!rst_n)
      kill[i] |=> (!flags[i] && !trig[i]));
  end
endmodule

bind quad_pit pit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .we(bus_we), .addr(bus_addr),
  .wdata(bus_wdata), .tick(tick), .timeout(timeout), .kill(kill),
  .flags(flags), .trig(trig_o)
);

// File: tb/sim_quad_pit.sv
`timescale 1ns/1ps
module sim_quad_pit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  trig_o, irq_o;
  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] rv;

  always #2.5 clk = ~clk;

  quad_pit u0 (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
               .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_o(trig_o),
               .irq_o(irq_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  // expected trigger vector n edges after the run edge; channel i reload = l+i
  function automatic logic [3:0] exp_trig(input int n, input int m, input int l);
    logic [3:0] e;
    for (int i = 0; i < 4; i++) e[i] = (n % ((m + 1) * (l + i + 1))) == 0;
    return e;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), rv); chk("R10 reset", rv, 0);
    end
    chk("R10 reset trig", trig_o, 0);
    chk("R10 reset irq", irq_o, 0);

    // R10 map readback
    wr(4'h4, 16'h01FF); rd(4'h4, rv); chk("R10 mtld", rv, 16'h00FF);
    wr(4'hA, 16'hBEEF); rd(4'hA, rv); chk("R10 ld2", rv, 16'hBEEF);
    wr(4'h0, 16'h0002); rd(4'h0, rv); chk("R10 ctrl", rv, 0);
    wr(4'h6, 16'h1234); rd(4'h6, rv); chk("R10 hole", rv, 0);

    // R1 R2 R3 R6 R7 sweep
    for (int m = 0; m < 4; m++) begin
      for (int l = 1; l < 4; l++) begin
        int pmax;
        wr(4'h4, 16'(m));
        for (int i = 0; i < 4; i++) wr(4'(8 + i), 16'(l + i));
        wr(4'h1, 16'hF);
        wr(4'h2, 16'h5);
        for (int k = 0; k < 4; k++) begin step(); chk("R7 idle trig", trig_o, 0); end
        rd(4'h3, rv); chk("R7 idle flags", rv, 0);
        wr(4'h0, 16'h1);
        pmax = (m + 1) * (l + 4);
        for (int n = 1; n <= 2 * pmax; n++) begin
          step();
          chk("R1 R2 trigger timing", trig_o, exp_trig(n, m, l));
        end
        rd(4'h3, rv); chk("R2 flags set", rv, 16'hF);
        chk("R3 irq", irq_o, 4'h5);
        wr(4'h0, 16'h0);
        rd(4'h3, rv); chk("R6 run clear", rv, 0);
        chk("R6 irq after run clear", irq_o, 0);
      end
    end

    // R8 force-load: M=1, L=2 -> period 6
    wr(4'h4, 16'd1); wr(4'h8, 16'd2); wr(4'h1, 16'h1); wr(4'h2, 16'h0);
    wr(4'h0, 16'h1);
    for (int n = 1; n <= 2; n++) begin step(); chk("R8 pre", trig_o, 0); end
    wr(4'h0, 16'h3);
    for (int n = 4; n <= 12; n++) begin
      step(); chk("R8 restart", trig_o, (n == 9) ? 4'h1 : 4'h0);
    end
    wr(4'h0, 16'h0);

    // R9 disabled channel: M=1, ch0..2 reload 1 (period 4), ch3 reload 3
    wr(4'h4, 16'd1);
    for (int i = 0; i < 3; i++) wr(4'(8 + i), 16'd1);
    wr(4'hB, 16'd3);
    wr(4'h1, 16'h7);
    wr(4'h0, 16'h1);
    for (int n = 1; n <= 12; n++) begin
      step(); chk("R9 disabled low", trig_o, (n % 4 == 0) ? 4'h7 : 4'h0);
    end
    wr(4'h1, 16'hF); // edge 13
    for (int n = 14; n <= 24; n++) begin
      step();
      chk("R9 held at reload", trig_o,
          ((n % 4 == 0) ? 4'h7 : 4'h0) | ((n == 20) ? 4'h8 : 4'h0));
    end
    wr(4'h0, 16'h0);

    // R4 R5 R6 flag clearing: M=1, ch0 reload 3 (P=8), ch1 reload 5 (P=12)
    wr(4'h8, 16'd3); wr(4'h9, 16'd5); wr(4'h1, 16'h3); wr(4'h2, 16'h3);
    wr(4'h0, 16'h1);
    for (int n = 1; n <= 7; n++) step();
    wr(4'h3, 16'h3); // edge 8, ch0 times out here
    rd(4'h3, rv); chk("R5 hit wins", rv, 16'h1);
    chk("R5 irq", irq_o, 4'h1);
    wr(4'h3, 16'h1); // edge 9
    rd(4'h3, rv); chk("R4 clear one", rv, 0);
    for (int n = 10; n <= 12; n++) step();
    rd(4'h3, rv); chk("R1 ch1 flag", rv, 16'h2);
    for (int n = 13; n <= 16; n++) step();
    rd(4'h3, rv); chk("R1 both flags", rv, 16'h3);
    wr(4'h3, 16'h0); // edge 17
    rd(4'h3, rv); chk("R4 zero keeps", rv, 16'h3);
    wr(4'h3, 16'h3); // edge 18
    rd(4'h3, rv); chk("R4 multi clear", rv, 0);
    for (int n = 19; n <= 24; n++) step();
    rd(4'h3, rv); chk("R1 both again", rv, 16'h3);
    wr(4'h2, 16'h1); // edge 25
    rd(4'h3, rv); chk("R6 ien clear", rv, 16'h1);
    chk("R3 irq after ien clear", irq_o, 4'h1);
    wr(4'h1, 16'h2); // edge 26
    rd(4'h3, rv); chk("R6 chen clear", rv, 0);
    chk("R3 irq none", irq_o, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule